// File: doc/BRIEF.md
# Hardware Page Table Walker

This block runs after a miss in the second-level translation cache and turns a 36-bit virtual page number into a 40-bit physical frame number. It reads a four-level radix page table from memory. Each level indexes a 512-entry table with nine bits of the page number, and each read depends on the entry returned by the level above. The first read starts from the frame given on the table-base input, which is sampled when a request is accepted. The walker serves one walk at a time. A request is accepted on a valid/ready handshake, and the result stays on the response port until the requester takes it.

The walk can end early in three ways. An entry with its page-size bit set at the second or third level is a 1 GiB or 2 MiB leaf. An entry that is not present raises a fault. A hit in a small directory-entry cache skips the three upper levels. That cache is fully associative and keeps the frame pointers of recently read third-level directory entries. It is tagged by the upper 27 page-number bits, refilled round-robin, and cleared in one cycle by a flush input. The memory port issues one read at a time and may take any number of cycles to answer.

Top module: `pt_walker`

## Requirements
- R1: During and right after reset, req_ready is 1, and rsp_valid and mem_req_valid are 0.
- R2: A full walk makes four reads. The read at level L (L = 3 down to 0) has address {F, vpn[9L+8:9L], 3'b000}. F is root_base for L = 3, and otherwise the frame field of the previous entry. An entry has its present flag in bit 0, its page-size flag in bit 7 and its frame in bits 51:12. A present entry at level 0 gives rsp_pfn equal to its frame and rsp_size 0 (4 KiB).
- R3: A present entry with the page-size flag set ends the walk with no further read. At level 2 it gives rsp_size 2 and rsp_pfn = {frame[39:18], vpn[17:0]}. At level 1 it gives rsp_size 1 and rsp_pfn = {frame[39:9], vpn[8:0]}. The flag is ignored at levels 3 and 0.
- R4: A non-present entry at any level ends the walk with no further read. The response has rsp_fault 1, rsp_pfn 0 and rsp_size 0.
- R5: A request whose vpn[35:9] matches a valid directory-cache entry makes exactly one read, at {cached frame, vpn[8:0], 3'b000}.
- R6: Each present, non-leaf level-1 entry that a walk reads is installed in the 32-entry cache. Slots are refilled in round-robin order, so the 33rd install evicts the first.
- R7: flush clears every cache entry by the next cycle and wins over an install in the same cycle. A walk in progress still completes correctly.
- R8: mem_req_valid stays high with mem_req_addr unchanged until mem_rsp_valid, for any latency. mem_req_valid is low while a response is held.
- R9: req_ready is low from acceptance until the response is taken. A req_valid that arrives meanwhile has no effect.
- R10: rsp_pfn, rsp_size and rsp_fault stay unchanged while rsp_valid is high and rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 40 | Frame of the top-level table |
| flush | input | 1 | Invalidate the directory cache |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request taken |
| req_vpn | input | 36 | Virtual page number to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pfn | output | 40 | Physical frame number |
| rsp_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| rsp_fault | output | 1 | Page fault |
| mem_req_valid | output | 1 | Table read pending |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry |

## Verification
A request goes into memory one cycle after acceptance. Each read whose data arrives k cycles after the read appears adds k+1 cycles, and the response shows on the edge that takes the last entry. The expected time therefore depends on how many reads the walk needs and on the latency the bench chose. The bench polls the response on falling edges instead of predicting a fixed cycle. It then checks how many reads were served against the count its own model expects, which includes the directory-cache state. Cache clears are checked on the edge after flush, and held outputs are compared on every cycle of a stalled response.

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker #(
  parameter int VPN_W = 36,
  parameter int PFN_W = 40,
  parameter int IDX_W = 9,
  parameter int ENT_W = 64,
  parameter int DC_N  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PFN_W-1:0]  root_base,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [1:0]        rsp_size,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  output logic [PFN_W+11:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data
);
  localparam int PA_W   = PFN_W + 12;
  localparam int TAG_W  = VPN_W - IDX_W;
  localparam int DC_IW  = (DC_N > 1) ? $clog2(DC_N) : 1;
  localparam int P_BIT  = 0;
  localparam int PS_BIT = 7;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_RESP} st_t;

  st_t              st;
  logic [1:0]       lvl;
  logic [PA_W-1:0]  addr;
  logic [VPN_W-1:0] vpn_q;
  logic [PFN_W-1:0] pfn_q;
  logic [1:0]       size_q;
  logic             fault_q;

  logic [DC_N-1:0]  dc_vld;
  logic [TAG_W-1:0] dc_tag [DC_N];
  logic [PFN_W-1:0] dc_frm [DC_N];
  logic [DC_IW-1:0] rr;

  function automatic logic [IDX_W-1:0] idx_of(input logic [VPN_W-1:0] v, input logic [1:0] l);
    return IDX_W'(v >> (IDX_W * int'(l)));
  endfunction

  wire             ent_pres = mem_rsp_data[P_BIT];
  wire             ent_ps   = mem_rsp_data[PS_BIT];
  wire [PFN_W-1:0] ent_frm  = mem_rsp_data[PA_W-1:12];
  wire             unused_ent = ^{mem_rsp_data[ENT_W-1:PA_W], mem_rsp_data[11:PS_BIT+1],
                                  mem_rsp_data[PS_BIT-1:P_BIT+1]};
  wire             ent_leaf = (lvl == 2'd0) || (ent_ps && lvl != 2'd3);
  wire             take     = (st == S_WALK) && mem_rsp_valid;
  wire             fill     = take && lvl == 2'd1 && ent_pres && !ent_ps && !flush;

  logic [5:0] shamt;
  assign shamt = 6'(IDX_W * int'(lvl));
  wire [PFN_W-1:0] lo_mask  = ~({PFN_W{1'b1}} << shamt);
  wire [PFN_W-1:0] leaf_pfn = (ent_frm & ~lo_mask) | (PFN_W'(vpn_q) & lo_mask);

  logic             hit;
  logic [PFN_W-1:0] hit_frm;
  always_comb begin
    hit     = 1'b0;
    hit_frm = '0;
    for (int i = 0; i < DC_N; i++)
      if (dc_vld[i] && dc_tag[i] == req_vpn[VPN_W-1:IDX_W]) begin
        hit     = 1'b1;
        hit_frm = dc_frm[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lvl     <= '0;
      addr    <= '0;
      vpn_q   <= '0;
      pfn_q   <= '0;
      size_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          st    <= S_WALK;
          vpn_q <= req_vpn;
          if (hit) begin
            lvl  <= 2'd0;
            addr <= {hit_frm, idx_of(req_vpn, 2'd0), 3'b000};
          end else begin
            lvl  <= 2'd3;
            addr <= {root_base, idx_of(req_vpn, 2'd3), 3'b000};
          end
        end
        S_WALK: if (mem_rsp_valid) begin
          if (!ent_pres) begin
            st      <= S_RESP;
            fault_q <= 1'b1;
            pfn_q   <= '0;
            size_q  <= 2'd0;
          end else if (ent_leaf) begin
            st      <= S_RESP;
            fault_q <= 1'b0;
            pfn_q   <= leaf_pfn;
            size_q  <= lvl;
          end else begin
            lvl  <= lvl - 2'd1;
            addr <= {ent_frm, idx_of(vpn_q, lvl - 2'd1), 3'b000};
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_vld <= '0;
      rr     <= '0;
    end else if (flush) begin
      dc_vld <= '0;
    end else if (fill) begin
      dc_vld[rr] <= 1'b1;
      rr         <= (rr == DC_IW'(DC_N - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      dc_tag[rr] <= vpn_q[VPN_W-1:IDX_W];
      dc_frm[rr] <= ent_frm;
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_WALK);
  assign rsp_valid     = (st == S_RESP);
  assign mem_req_addr  = addr;
  assign rsp_pfn       = pfn_q;
  assign rsp_size      = size_q;
  assign rsp_fault     = fault_q;
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk #(
  parameter int PFN_W = 40,
  parameter int PA_W  = 52,
  parameter int DC_N  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic [1:0]       rsp_size,
  input logic             rsp_fault,
  input logic             mem_req_valid,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [DC_N-1:0]  dc_vld
);
  assert_fault_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pfn == '0 && rsp_size == 2'd0);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> dc_vld == '0);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_addr));

  assert_no_read_in_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || rsp_valid) |-> !req_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pfn) && $stable(rsp_size) && $stable(rsp_fault));
endmodule

bind pt_walker pt_walker_chk #(.PFN_W(PFN_W), .PA_W(PA_W), .DC_N(DC_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pfn(rsp_pfn),
  .rsp_size(rsp_size), .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .dc_vld(dc_vld)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] root_base = 40'h0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:0] req_vpn = 36'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [39:0] rsp_pfn;
  logic [1:0]  rsp_size;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = 64'h0;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pfn(rsp_pfn),
    .rsp_size(rsp_size), .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always #2.5 clk = ~clk;

  int nvec = 0;
  int nerr = 0;
  int rd_cnt = 0;
  int fault_th = 0;
  int lat_force = -1;
  int mlat = 0;
  int mcnt = 0;
  logic [51:0] maddr0 = 52'h0;
  logic [63:0] seed_k = 64'h5bd1e9955bd1e995;

  logic [26:0] m_tag [32];
  bit          m_vld [32];
  int          m_ptr = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] pte(input logic [51:0] a);
    logic [63:0] x;
    x = {12'h0, a} ^ seed_k;
    x = x * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 31);
    x = x * 64'hBF58476D1CE4E5B9;
    x = x ^ (x >> 29);
    x[0] = (int'(x[5:0]) >= fault_th);
    x[7] = (x[63:61] == 3'd0);
    return x;
  endfunction

  task automatic pure_walk(input logic [35:0] v, input int start_lvl, input logic [39:0] start_frm,
                           output logic [39:0] pfn, output logic [1:0] size, output bit fault,
                           output int reads, output bit fill, output logic [39:0] fill_frm,
                           output logic [63:0] last_e);
    logic [39:0] f;
    logic [39:0] mask;
    logic [63:0] e;
    f = start_frm;
    pfn = '0; size = '0; fault = 0; reads = 0; fill = 0; fill_frm = '0; last_e = '0;
    for (int l = start_lvl; l >= 0; l--) begin
      e = pte({f, v[l*9 +: 9], 3'b000});
      last_e = e;
      reads++;
      if (!e[0]) begin
        fault = 1;
        return;
      end
      if (l == 0 || (e[7] && (l == 1 || l == 2))) begin
        mask = (40'd1 << (9 * l)) - 40'd1;
        pfn  = (e[51:12] & ~mask) | ({4'd0, v} & mask);
        size = 2'(l);
        return;
      end
      if (l == 1) begin
        fill = 1;
        fill_frm = e[51:12];
      end
      f = e[51:12];
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < 32; i++) m_vld[i] = 0;
  endtask

  task automatic model_lookup(input logic [35:0] v, output bit h, output logic [39:0] frm);
    logic [39:0] ff [32];
    h = 0; frm = '0;
    for (int i = 0; i < 32; i++) if (m_vld[i] && m_tag[i] == v[35:9]) begin
      h = 1;
      frm = m_frm_of(i);
    end
    ff[0] = '0;
  endtask

  logic [39:0] m_frm [32];
  function automatic logic [39:0] m_frm_of(input int i);
    return m_frm[i];
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      mcnt = 0;
    end else if (mem_rsp_valid) begin
      mem_rsp_valid = 1'b0;
      mcnt = 0;
      mlat = (lat_force >= 0) ? lat_force : int'($urandom_range(0, 4));
    end else if (mem_req_valid) begin
      if (mcnt == 0) maddr0 = mem_req_addr;
      if (mcnt >= mlat) begin
        chk(mem_req_addr == maddr0, "R8 address held while waiting", 64'(mem_req_addr), 64'(maddr0));
        mem_rsp_data  = pte(mem_req_addr);
        mem_rsp_valid = 1'b1;
        rd_cnt++;
      end else begin
        mcnt++;
      end
    end
  end

  task automatic run_walk(input logic [35:0] v, input string rq, input bit poke_busy,
                          input bit flush_mid, input bit flush_in_rsp, input int hold);
    bit h; bit ef; bit fl;
    logic [39:0] hf; logic [39:0] ep; logic [1:0] es; int er; logic [39:0] flf; logic [63:0] le;
    logic [39:0] p0; logic [1:0] s0; logic f0;
    model_lookup(v, h, hf);
    if (h) pure_walk(v, 0, hf, ep, es, ef, er, fl, flf, le);
    else   pure_walk(v, 3, root_base, ep, es, ef, er, fl, flf, le);
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1;
    req_vpn = v;
    @(negedge clk);
    req_valid = 1'b0;
    if (flush_mid) begin
      flush = 1'b1;
      model_flush();
      @(negedge clk);
      flush = 1'b0;
    end
    if (poke_busy) begin
      req_valid = 1'b1;
      req_vpn = ~v;
      chk(req_ready == 1'b0, "R9 not ready while busy", 64'(req_ready), 64'd0);
    end
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    if (fl) begin
      m_tag[m_ptr] = v[35:9];
      m_frm[m_ptr] = flf;
      m_vld[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % 32;
    end
    chk(rsp_pfn == ep,   {rq, " frame"},      64'(rsp_pfn),   64'(ep));
    chk(rsp_size == es,  {rq, " size"},       64'(rsp_size),  64'(es));
    chk(rsp_fault == ef, {rq, " fault"},      64'(rsp_fault), 64'(ef));
    chk(rd_cnt == er,    {rq, " read count"}, 64'(rd_cnt),    64'(er));
    if (flush_in_rsp) begin
      flush = 1'b1;
      model_flush();
      @(negedge clk);
      flush = 1'b0;
    end
    p0 = rsp_pfn; s0 = rsp_size; f0 = rsp_fault;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pfn == p0 && rsp_size == s0 && rsp_fault == f0,
          "R10 response held", 64'(rsp_pfn), 64'(p0));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 ready after response taken",
        64'({rsp_valid, req_ready}), 64'd1);
  endtask

  task automatic find_vpn(input int kind, output logic [35:0] v);
    logic [39:0] p; logic [1:0] s; bit f; int r; bit fl; logic [39:0] ff; logic [63:0] le;
    bit ok;
    for (int n = 0; n < 20000; n++) begin
      v = {4'($urandom), $urandom};
      pure_walk(v, 3, root_base, p, s, f, r, fl, ff, le);
      case (kind)
        0: ok = !f && r == 4 && !le[7];
        1: ok = !f && s == 2'd2;
        2: ok = !f && s == 2'd1;
        3: ok = !f && r == 4 && pte({root_base, v[35:27], 3'b000})[7];
        4: ok = !f && r == 4 && le[7];
        5: ok = f && r == 3;
        6: ok = f && r == 1;
        default: ok = f && r == 4;
      endcase
      if (ok) return;
    end
    $display("search for walk kind %0d gave up", kind);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [35:0] v; logic [35:0] va; logic [35:0] vb;
    logic [26:0] pre [6];
    logic [26:0] rr_pre [34];
    int seed_init;
    seed_init = int'($urandom(32'd4242));
    model_flush();
    root_base = {$urandom, 8'($urandom)};

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 in reset",
        64'({req_ready, rsp_valid, mem_req_valid}), 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 after reset",
        64'({req_ready, rsp_valid, mem_req_valid}), 64'd4);

    fault_th = 0;
    find_vpn(0, v);
    run_walk(v, "R2 full walk", 0, 0, 0, 0);
    run_walk({v[35:9], ~v[8:0]}, "R5 cached directory", 0, 0, 0, 1);
    find_vpn(1, v);
    run_walk(v, "R3 1G leaf", 0, 0, 0, 0);
    find_vpn(2, v);
    run_walk(v, "R3 2M leaf", 0, 0, 0, 2);
    find_vpn(3, v);
    run_walk(v, "R3 flag ignored at root", 0, 0, 0, 0);
    find_vpn(4, v);
    run_walk(v, "R3 flag ignored at last level", 0, 0, 0, 0);

    fault_th = 16;
    find_vpn(6, v);
    run_walk(v, "R4 fault at root", 0, 0, 0, 0);
    find_vpn(5, v);
    run_walk(v, "R4 fault at directory", 0, 0, 0, 0);
    run_walk(v, "R4 faulting directory not cached", 0, 0, 0, 0);
    find_vpn(7, v);
    run_walk(v, "R4 fault at last level", 0, 0, 0, 1);
    fault_th = 0;

    lat_force = 25;
    find_vpn(0, v);
    run_walk(v, "R8 long latency", 0, 0, 0, 0);
    lat_force = 0;
    run_walk({v[35:9], 9'h1}, "R8 zero latency", 0, 0, 0, 0);
    lat_force = -1;

    find_vpn(0, va);
    run_walk(va, "R9 busy request ignored", 1, 0, 0, 1);

    find_vpn(0, vb);
    run_walk(vb, "R7 before flush", 0, 0, 0, 0);
    @(negedge clk); flush = 1'b1; model_flush(); @(negedge clk); flush = 1'b0;
    run_walk(vb, "R7 full walk after flush", 0, 0, 0, 0);
    run_walk({vb[35:9], 9'h7}, "R7 flush while response held", 0, 0, 1, 2);
    run_walk(vb, "R7 refetch after flush in response", 0, 0, 0, 0);
    run_walk(va, "R7 flush during walk", 0, 1, 0, 0);
    run_walk({va[35:9], 9'h3}, "R7 install after mid-walk flush", 0, 0, 0, 0);

    @(negedge clk); flush = 1'b1; model_flush(); @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 34; i++) begin
      find_vpn(0, v);
      rr_pre[i] = v[35:9];
      run_walk(v, "R6 fill", 0, 0, 0, 0);
    end
    run_walk({rr_pre[0], 9'h5}, "R6 oldest evicted", 0, 0, 0, 0);
    run_walk({rr_pre[3], 9'h5}, "R6 survivor hits", 0, 0, 0, 0);
    run_walk({rr_pre[1], 9'h5}, "R6 second evicted", 0, 0, 0, 0);

    for (int i = 0; i < 6; i++) pre[i] = 27'($urandom);
    fault_th = 2;
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 1) == 0) v = {pre[$urandom_range(0, 5)], 9'($urandom)};
      else v = {4'($urandom), $urandom};
      run_walk(v, "R2 R3 R5 random walk", $urandom_range(0, 7) == 0, 0, 0, $urandom_range(0, 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule